// File: doc/BRIEF.md
# Outbound Request Deadline Tracker

This block watches requests that leave a node and expect an answer. Each request carries a small tag. When a read or a write-with-acknowledge request is issued, the tag's slot stores an absolute deadline: the programmed time-out length added to a shared free-running tick counter. Each slot compares its deadline with the tick every cycle. If the tick reaches the deadline before a response with the same tag arrives, the slot is released and the tag's bit on a time-out vector pulses for one cycle.

The block also keeps three progress counters for software to read:
- writes accepted on the memory-mapped slave side;
- write request packets that were handed on toward the transport side;
- write-with-acknowledge requests that are still waiting.

Posted and streaming writes are counted as packets but never hold a slot. A response whose tag has no live slot raises a one-cycle error pulse. The requester sees a stall flag while every slot is busy.

Top module: `rsp_deadline_tracker`

## Requirements
- R1: Request kinds are coded as 0 = read, 1 = write with acknowledge, 2 = posted write, 3 = streaming write. Only kinds 0 and 1 occupy the slot of their tag. Kinds 2 and 3 never cause a time-out, and a later response to their tag is treated as unknown.
- R2: A tracked request accepted at clock edge E with programmed length V (V >= 1) pulses bit `tag` of `timeout_o` for exactly one cycle. The pulse becomes visible after edge E+V. The deadline arithmetic wraps modulo 2^TICK_W, so a deadline that crosses the wrap point fires just as punctually. Several tags may pulse in the same cycle.
- R3: A response to an outstanding tag frees the slot, and no time-out is reported for that request. This also holds when the response is sampled at the same edge that would have registered the time-out.
- R4: A response to a tag with no outstanding request changes no slot and no counter. It raises `rsp_err_o` for the single cycle after it is sampled.
- R5: `iss_stall_o` is high exactly while all 2^TAG_W slots are busy. A tracked issue to a tag whose slot is busy is rejected: nothing is stored and nothing is counted.
- R6: `wr_init_cnt_o` increases by one for each cycle with `wr_accept_i` high.
- R7: `wr_pkt_cnt_o` increases by one for each accepted issue of kind 1, 2 or 3.
- R8: `pend_cnt_o` increases by one when a kind 1 issue is accepted. It decreases by one when such a request is either answered or times out.
- R9: After reset, all counters are zero, and `iss_stall_o`, `rsp_err_o` and `timeout_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_timeout_i | input | TICK_W | Time-out length in cycles, applied at issue |
| wr_accept_i | input | 1 | A write was accepted on the slave side |
| iss_valid_i | input | 1 | A request is being issued this cycle |
| iss_kind_i | input | 2 | Request kind (0 read, 1 write-ack, 2 posted, 3 streaming) |
| iss_tag_i | input | TAG_W | Tag of the issued request |
| iss_stall_o | output | 1 | All slots busy |
| rsp_valid_i | input | 1 | A response arrives this cycle |
| rsp_tag_i | input | TAG_W | Tag of the response |
| rsp_err_o | output | 1 | Pulse: the previous response matched no outstanding tag |
| timeout_o | output | 2^TAG_W | Per-tag time-out pulse |
| wr_init_cnt_o | output | CNT_W | Count of slave-side writes |
| wr_pkt_cnt_o | output | CNT_W | Count of write request packets sent on |
| pend_cnt_o | output | clog2(2^TAG_W+1) | Write-with-acknowledge requests awaiting completion |

## Verification
The hardest case to create from the ports is a response and a deadline match that hit the same tag at the same edge. The bench records the absolute edge at which each tracked issue was sampled and the deadline edge that follows from it. It then waits until the cycle just before that edge and drives the response there. With a narrow tick width the bench also runs long enough for a deadline to cross the counter's wrap point. It lines up two requests with different lengths so that they expire together, and it fills every slot to raise the stall flag before trying one rejected issue.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

   typedef enum logic [1:0] {
      REQ_READ         = 2'd0,
      REQ_WRITE_ACK    = 2'd1,
      REQ_WRITE_POSTED = 2'd2,
      REQ_WRITE_STREAM = 2'd3
   } req_kind_e;

   // Requests that expect an answer and therefore hold a slot.
   function automatic logic kind_needs_reply(input req_kind_e k);
      return (k == REQ_READ) || (k == REQ_WRITE_ACK);
   endfunction

   function automatic logic kind_is_write(input req_kind_e k);
      return k != REQ_READ;
   endfunction

endpackage

// File: rtl/rdt_tick.sv
module rdt_tick #(
   parameter int TICK_W = 24
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   output logic [TICK_W-1:0] tick_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tick_o <= '0;
      else         tick_o <= tick_o + 1'b1;
   end

endmodule

// File: rtl/rdt_evt_cnt.sv
module rdt_evt_cnt #(
   parameter int W        = 32,
   parameter bit SATURATE = 1'b0
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         inc_i,
   output logic [W-1:0] q_o
);

   localparam logic [W-1:0] TOP = '1;

   if (W < 2) begin : g_chk_w
      $error("rdt_evt_cnt: W must be at least 2");
   end

   if (SATURATE) begin : g_sat
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                 q_o <= '0;
         else if (inc_i && q_o != TOP) q_o <= q_o + 1'b1;
      end
   end else begin : g_wrap
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)    q_o <= '0;
         else if (inc_i) q_o <= q_o + 1'b1;
      end
   end

   // R6 and R7 share this counter: every event below the top step adds one.
   a_r7_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc_i && q_o != TOP) |=> q_o == $past(q_o) + 1'b1);

endmodule

// File: rtl/rdt_slot_bank.sv
module rdt_slot_bank #(
   parameter int TAG_W  = 4,
   parameter int TICK_W = 24
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic [TICK_W-1:0]       tick_i,
   input  logic [TICK_W-1:0]       len_i,
   input  logic [(1<<TAG_W)-1:0]   set_i,
   input  logic                    set_wack_i,
   input  logic [(1<<TAG_W)-1:0]   rsp_clr_i,
   output logic [(1<<TAG_W)-1:0]   busy_o,
   output logic [(1<<TAG_W)-1:0]   wack_o,
   output logic [(1<<TAG_W)-1:0]   expire_o
);

   localparam int SLOTS = 1 << TAG_W;

   // One adder shared by every slot: the absolute deadline of a new issue.
   logic [TICK_W-1:0] due_new;
   assign due_new = tick_i + len_i;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      logic [TICK_W-1:0] due_q;
      logic              busy_q;
      logic              wack_q;
      logic              match;

      assign match       = busy_q && (due_q == tick_i);
      assign expire_o[g] = match && !rsp_clr_i[g];
      assign busy_o[g]   = busy_q;
      assign wack_o[g]   = wack_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            busy_q <= 1'b0;
            wack_q <= 1'b0;
            due_q  <= '0;
         end else if (set_i[g]) begin
            busy_q <= 1'b1;
            wack_q <= set_wack_i;
            due_q  <= due_new;
         end else if (rsp_clr_i[g] || match) begin
            busy_q <= 1'b0;
         end
      end

      a_r5_no_double_book: assert property (@(posedge clk_i) disable iff (!rst_ni)
         set_i[g] |-> !busy_q);

      a_r2_release_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
         expire_o[g] |=> !busy_q);

      a_r3_clear_only_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
         rsp_clr_i[g] |-> busy_q);
   end

   a_r3_single_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(rsp_clr_i));

   a_r5_single_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(set_i));

endmodule

// File: rtl/rsp_deadline_tracker.sv
module rsp_deadline_tracker
   import rdt_pkg::*;
#(
   parameter int TAG_W        = 4,
   parameter int TICK_W       = 24,
   parameter int CNT_W        = 32,
   parameter bit CNT_SATURATE = 1'b0
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic [TICK_W-1:0]                 cfg_timeout_i,
   input  logic                              wr_accept_i,
   input  logic                              iss_valid_i,
   input  logic [1:0]                        iss_kind_i,
   input  logic [TAG_W-1:0]                  iss_tag_i,
   output logic                              iss_stall_o,
   input  logic                              rsp_valid_i,
   input  logic [TAG_W-1:0]                  rsp_tag_i,
   output logic                              rsp_err_o,
   output logic [(1<<TAG_W)-1:0]             timeout_o,
   output logic [CNT_W-1:0]                  wr_init_cnt_o,
   output logic [CNT_W-1:0]                  wr_pkt_cnt_o,
   output logic [$clog2((1<<TAG_W)+1)-1:0]   pend_cnt_o
);

   localparam int SLOTS = 1 << TAG_W;
   localparam int PW    = $clog2(SLOTS + 1);

   if (TAG_W < 1 || TAG_W > 6) begin : g_chk_tag
      $error("rsp_deadline_tracker: TAG_W must lie in 1..6");
   end
   if (TICK_W < 4 || TICK_W > 32) begin : g_chk_tick
      $error("rsp_deadline_tracker: TICK_W must lie in 4..32");
   end
   if (CNT_W < 2) begin : g_chk_cnt
      $error("rsp_deadline_tracker: CNT_W must be at least 2");
   end

   req_kind_e         kind;
   logic              tracked;
   logic              accept;
   logic              rsp_known;
   logic [SLOTS-1:0]  set_vec;
   logic [SLOTS-1:0]  clr_vec;
   logic [SLOTS-1:0]  busy;
   logic [SLOTS-1:0]  wack;
   logic [SLOTS-1:0]  expire;
   logic [TICK_W-1:0] tick;
   logic [PW-1:0]     pend_dec;
   logic              pend_inc;
   logic [PW-1:0]     pend_q;
   logic              err_q;
   logic [SLOTS-1:0]  to_q;

   assign kind      = req_kind_e'(iss_kind_i);
   assign tracked   = kind_needs_reply(kind);
   assign accept    = iss_valid_i && !(tracked && busy[iss_tag_i]);
   assign set_vec   = (accept && tracked) ? (SLOTS'(1) << iss_tag_i) : '0;
   assign rsp_known = rsp_valid_i && busy[rsp_tag_i];
   assign clr_vec   = rsp_known ? (SLOTS'(1) << rsp_tag_i) : '0;
   assign pend_inc  = accept && (kind == REQ_WRITE_ACK);

   rdt_tick #(.TICK_W(TICK_W)) tick_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick)
   );

   rdt_slot_bank #(.TAG_W(TAG_W), .TICK_W(TICK_W)) bank_i (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .len_i      (cfg_timeout_i),
      .set_i      (set_vec),
      .set_wack_i (kind == REQ_WRITE_ACK),
      .rsp_clr_i  (clr_vec),
      .busy_o     (busy),
      .wack_o     (wack),
      .expire_o   (expire)
   );

   rdt_evt_cnt #(.W(CNT_W), .SATURATE(CNT_SATURATE)) init_cnt_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (wr_accept_i),
      .q_o    (wr_init_cnt_o)
   );

   rdt_evt_cnt #(.W(CNT_W), .SATURATE(CNT_SATURATE)) pkt_cnt_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .inc_i  (accept && kind_is_write(kind)),
      .q_o    (wr_pkt_cnt_o)
   );

   // Write-with-acknowledge completions this cycle: expiries plus one answer.
   always_comb begin
      pend_dec = '0;
      for (int i = 0; i < SLOTS; i++) begin
         if (expire[i] && wack[i]) pend_dec = pend_dec + 1'b1;
      end
      if (rsp_known && wack[rsp_tag_i]) pend_dec = pend_dec + 1'b1;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_q <= '0;
         err_q  <= 1'b0;
         to_q   <= '0;
      end else begin
         pend_q <= pend_q + PW'(pend_inc) - pend_dec;
         err_q  <= rsp_valid_i && !busy[rsp_tag_i];
         to_q   <= expire;
      end
   end

   assign pend_cnt_o  = pend_q;
   assign rsp_err_o   = err_q;
   assign timeout_o   = to_q;
   assign iss_stall_o = &busy;

   a_r3_answer_beats_deadline: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_known |=> !timeout_o[$past(rsp_tag_i)]);

   a_r4_err_needs_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_err_o |-> $past(rsp_valid_i));

   a_r8_pend_matches_slots: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pend_cnt_o == PW'($countones(busy & wack)));

   a_r2_timeout_freed_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout_o != '0 |-> (timeout_o & busy & ~$past(set_vec)) == '0);

endmodule

// File: tb/rsp_deadline_tracker_tb_top.sv
`timescale 1ns/1ps
module rsp_deadline_tracker_tb_top;

   localparam int TAG_W  = 4;
   localparam int TICK_W = 12;
   localparam int CNT_W  = 16;
   localparam int NS     = 1 << TAG_W;
   localparam int PW     = $clog2(NS + 1);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [TICK_W-1:0] cfg_timeout = '0;
   logic              wr_accept = 1'b0;
   logic              iss_valid = 1'b0;
   logic [1:0]        iss_kind = '0;
   logic [TAG_W-1:0]  iss_tag = '0;
   logic              iss_stall;
   logic              rsp_valid = 1'b0;
   logic [TAG_W-1:0]  rsp_tag = '0;
   logic              rsp_err;
   logic [NS-1:0]     timeout_v;
   logic [CNT_W-1:0]  wr_init_cnt;
   logic [CNT_W-1:0]  wr_pkt_cnt;
   logic [PW-1:0]     pend_cnt;

   always #4 clk = ~clk;

   rsp_deadline_tracker #(
      .TAG_W(TAG_W), .TICK_W(TICK_W), .CNT_W(CNT_W), .CNT_SATURATE(1'b0)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .cfg_timeout_i(cfg_timeout),
      .wr_accept_i(wr_accept), .iss_valid_i(iss_valid), .iss_kind_i(iss_kind),
      .iss_tag_i(iss_tag), .iss_stall_o(iss_stall), .rsp_valid_i(rsp_valid),
      .rsp_tag_i(rsp_tag), .rsp_err_o(rsp_err), .timeout_o(timeout_v),
      .wr_init_cnt_o(wr_init_cnt), .wr_pkt_cnt_o(wr_pkt_cnt), .pend_cnt_o(pend_cnt)
   );

   typedef struct { int tag; int due; } exp_t;
   exp_t exp_q[$];
   int   err_q[$];

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;
   bit mdl_busy[NS];
   bit mdl_wack[NS];
   int exp_init = 0;
   int exp_pkt = 0;
   int exp_pend = 0;
   logic [NS-1:0] mon_ev;
   bit mon_err;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   endtask

   // Monitor: 2 ns after each edge, pop the deadlines due at this edge.
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         mon_ev = '0;
         for (int i = exp_q.size() - 1; i >= 0; i--) begin
            if (exp_q[i].due == cyc) begin
               mon_ev[exp_q[i].tag] = 1'b1;
               mdl_busy[exp_q[i].tag] = 1'b0;
               if (mdl_wack[exp_q[i].tag]) exp_pend--;
               exp_q.delete(i);
            end else if (exp_q[i].due < cyc) begin
               chk(1'b0, "R2", "missed deadline tag", exp_q[i].tag, exp_q[i].due);
               exp_q.delete(i);
            end
         end
         if (mon_ev != '0 || timeout_v != '0)
            chk(timeout_v == mon_ev, "R2", "timeout_o", timeout_v, mon_ev);
         mon_err = (err_q.size() > 0) && (err_q[0] == cyc);
         if (mon_err) void'(err_q.pop_front());
         if (mon_err || rsp_err)
            chk(rsp_err == mon_err, "R4", "rsp_err_o", rsp_err, mon_err);
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic accept_write();
      wr_accept = 1'b1;
      exp_init++;
      @(negedge clk);
      wr_accept = 1'b0;
   endtask

   task automatic issue(input int kind, input int tag, input int len);
      bit trk;
      trk = (kind == 0) || (kind == 1);
      cfg_timeout = TICK_W'(len);
      iss_kind = 2'(kind);
      iss_tag = TAG_W'(tag);
      iss_valid = 1'b1;
      if (!(trk && mdl_busy[tag])) begin
         if (kind != 0) exp_pkt++;
         if (trk) begin
            mdl_busy[tag] = 1'b1;
            mdl_wack[tag] = (kind == 1);
            exp_q.push_back('{tag: tag, due: cyc + 1 + len});
         end
         if (kind == 1) exp_pend++;
      end
      @(negedge clk);
      iss_valid = 1'b0;
   endtask

   task automatic respond(input int tag);
      bit hit;
      hit = 1'b0;
      for (int i = exp_q.size() - 1; i >= 0; i--) begin
         if (exp_q[i].tag == tag && exp_q[i].due >= cyc + 1) begin
            hit = 1'b1;
            exp_q.delete(i);
         end
      end
      if (hit) begin
         mdl_busy[tag] = 1'b0;
         if (mdl_wack[tag]) exp_pend--;
      end else begin
         err_q.push_back(cyc + 1);
      end
      rsp_tag = TAG_W'(tag);
      rsp_valid = 1'b1;
      @(negedge clk);
      rsp_valid = 1'b0;
   endtask

   function automatic int due_of(input int tag);
      for (int i = 0; i < exp_q.size(); i++)
         if (exp_q[i].tag == tag) return exp_q[i].due;
      return -1;
   endfunction

   task automatic chk_counts(input string req);
      chk(wr_init_cnt == CNT_W'(exp_init), "R6", {req, " wr_init_cnt_o"}, wr_init_cnt, exp_init);
      chk(wr_pkt_cnt == CNT_W'(exp_pkt), "R7", {req, " wr_pkt_cnt_o"}, wr_pkt_cnt, exp_pkt);
      chk(pend_cnt == PW'(exp_pend), "R8", {req, " pend_cnt_o"}, pend_cnt, exp_pend);
   endtask

   task automatic drain();
      int guard;
      guard = 0;
      while ((exp_q.size() > 0 || err_q.size() > 0) && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      idle(2);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
   end

   initial begin
      int d;
      for (int i = 0; i < NS; i++) begin mdl_busy[i] = 1'b0; mdl_wack[i] = 1'b0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R9: reset state
      chk(wr_init_cnt == '0 && wr_pkt_cnt == '0, "R9", "counters after reset", wr_init_cnt, 0);
      chk(pend_cnt == '0, "R9", "pend after reset", pend_cnt, 0);
      chk(!iss_stall && !rsp_err && timeout_v == '0, "R9", "flags after reset",
          {iss_stall, rsp_err, timeout_v}, 0);

      // R6: slave-side write count
      repeat (5) accept_write();
      idle(1);
      chk_counts("R6 five accepts");

      // R1/R7: posted and streaming writes hold no slot
      issue(2, 3, 5);
      issue(3, 4, 5);
      idle(10);
      chk_counts("R7 untracked writes");
      respond(3);   // R1: no slot behind tag 3, so this is an unknown answer
      idle(2);

      // R2: a read expires after exactly its length
      issue(0, 3, 20);
      drain();
      chk(pend_cnt == '0, "R1", "read does not touch pending", pend_cnt, 0);

      // R3/R8: answered write-ack
      issue(1, 5, 30);
      idle(1);
      chk_counts("R8 after write-ack issue");
      idle(10);
      respond(5);
      idle(1);
      chk_counts("R3 answered write-ack");
      idle(30);

      // R8: write-ack timing out releases pending
      issue(1, 6, 10);
      drain();
      chk_counts("R8 write-ack expired");

      // R3: answer sampled at the deadline edge wins
      issue(1, 7, 8);
      d = due_of(7);
      while (cyc != d - 1) @(negedge clk);
      respond(7);
      idle(3);
      chk_counts("R3 same-edge answer");

      // R4: unknown tag, then an answer one edge too late
      respond(9);
      idle(2);
      issue(0, 8, 6);
      d = due_of(8);
      while (cyc != d) @(negedge clk);
      respond(8);
      drain();
      chk_counts("R4 late answers ignored");

      // R2: two tags expiring together
      issue(0, 1, 50);
      issue(1, 2, 49);
      chk(due_of(1) == due_of(2), "R2", "aligned deadlines", due_of(1), due_of(2));
      drain();
      chk_counts("R2 simultaneous expiries");

      // R5: fill every slot, then try a rejected issue
      for (int t = 0; t < NS; t++) issue(0, t, 300);
      chk(iss_stall == 1'b1, "R5", "stall with all slots busy", iss_stall, 1);
      issue(1, 4, 10);
      idle(1);
      chk_counts("R5 rejected issue not counted");
      respond(4);
      chk(iss_stall == 1'b0, "R5", "stall after a slot frees", iss_stall, 0);
      drain();
      chk(iss_stall == 1'b0, "R5", "stall after drain", iss_stall, 0);

      // R2: deadlines that cross the tick wrap point
      while (cyc < 4000) @(negedge clk);
      issue(0, 9, 200);
      issue(1, 10, 150);
      drain();
      chk_counts("R2 wrap-crossing deadlines");

      chk(exp_q.size() == 0, "R2", "all deadlines seen", exp_q.size(), 0);
      finish_run();
   end

endmodule